// File: doc/BRIEF.md
# Audio Sample Buffer with Rate Adapter

This block sits between a processor that writes 8-bit audio samples at a low rate and a serial formatter that consumes 16-bit samples at the converter rate. Samples are held in an eight-entry first-in first-out store. When the formatter asks for a sample, the oldest byte is widened to 16 bits, with the byte in the upper half and zeros in the lower half. The same value is then handed out a programmable number of times before the next byte is taken. This brings the slow write rate up to the converter rate.

Three flags tell software how the store is doing. The sample-request flag has hysteresis around the half-full mark, so software refills in bursts. The sticky under-run flag records that the formatter asked for data when none was left. The busy flag shows that the store is full. Each of the request and under-run flags can be enabled onto a single interrupt line.

Top module: `audio_sample_buffer`

## Requirements
- R1: The store holds 8 bytes. A write presented while busy is high is discarded and never appears at the output.
- R2: Every output sample is 16 bits: bits 15:8 carry the stored byte and bits 7:0 are always zero.
- R3: `dup_sel` sets how many consecutive requests are served by one stored byte: 00 gives 1, 01 gives 2, 10 gives 3, 11 gives 4. It is sampled when a new byte is fetched, so changing it in the middle of a run does not alter that run.
- R4: Bytes leave in the order they were written.
- R5: `samp_req` is 1 after reset. It is set when the fill level goes from 4 to 3.
- R6: `samp_req` is cleared when the fill level goes from 4 to 5. No other level change alters it, including a write and a fetch in the same cycle.
- R7: A request that needs a new byte while the store is empty sets `underrun`. `samp_out` then keeps its previous value, which is zero if no byte has ever been fetched.
- R8: `underrun` stays set until `underrun_clr` is pulsed. A new under-run in the same cycle as the clear leaves it set.
- R9: `busy` is high exactly when the store holds 8 bytes.
- R10: `irq` is high when (`samp_req` and `req_ie`) or (`underrun` and `urun_ie`).
- R11: `samp_out` changes only in the cycle after a `rd_req`. Without a request it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the processor |
| wr_byte | input | 8 | Sample byte to store |
| rd_req | input | 1 | One-cycle request for the next output sample |
| dup_sel | input | 2 | Repeat count select |
| underrun_clr | input | 1 | Clears the under-run flag |
| req_ie | input | 1 | Interrupt enable for the sample-request flag |
| urun_ie | input | 1 | Interrupt enable for the under-run flag |
| samp_out | output | 16 | Widened output sample |
| samp_req | output | 1 | Sample-request flag with hysteresis |
| underrun | output | 1 | Sticky under-run flag |
| busy | output | 1 | Store full |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest cases to reach are those where the repeat counter and the fill level interact. One is a change of `dup_sel` while a byte is still being repeated. Another is a write and a fetch landing in the same cycle with the level at exactly four. Reaching them from the ports means counting requests precisely. The bench first drives requests until a run ends on a known boundary. Only then does it change `dup_sel` or stack a write on the fetching request, so that it knows the level and the repeat position at every step. The collision of an under-run with its own clear is produced by asserting the clear on the request that starves.

// File: rtl/asb_pkg.sv
package asb_pkg;
  localparam int SAMPLE_W = 8;
  localparam int OUT_W    = 2 * SAMPLE_W;
  localparam int DUP_W    = 2;

  // Zero-extend on the right: byte becomes the upper half.
  function automatic logic [OUT_W-1:0] widen_sample(input logic [SAMPLE_W-1:0] b);
    return {b, {(OUT_W - SAMPLE_W){1'b0}}};
  endfunction

  // Number of extra repeats after the first output of a byte.
  function automatic logic [DUP_W-1:0] extra_repeats(input logic [DUP_W-1:0] sel);
    return sel;
  endfunction

  // Hysteresis update of the request flag at the half-full mark.
  function automatic logic sreq_update(input logic cur, input logic at_mark,
                                       input logic grow, input logic shrink);
    logic nxt;
    nxt = cur;
    if (at_mark && shrink) nxt = 1'b1;
    else if (at_mark && grow) nxt = 1'b0;
    return nxt;
  endfunction
endpackage

// File: rtl/asb_fifo.sv
module asb_fifo
  import asb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic                pop,
  input  logic [SAMPLE_W-1:0] wdata,
  output logic [SAMPLE_W-1:0] rdata,
  output logic                push_ok,
  output logic                full,
  output logic                empty,
  output logic [LW-1:0]       level
);
  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic pop_ok;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/asb_repeater.sv
module asb_repeater
  import asb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_req,
  input  logic [DUP_W-1:0]    dup_sel,
  input  logic                empty,
  input  logic [SAMPLE_W-1:0] head,
  output logic                pop,
  output logic                starve,
  output logic [OUT_W-1:0]    samp_out
);
  logic [DUP_W-1:0] left;
  logic fetch;

  assign fetch  = rd_req && (left == '0);
  assign pop    = fetch && !empty;
  assign starve = fetch && empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left     <= '0;
      samp_out <= '0;
    end else if (pop) begin
      samp_out <= widen_sample(head);
      left     <= extra_repeats(dup_sel);
    end else if (rd_req && !fetch) begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/asb_flags.sv
module asb_flags #(
  parameter int DEPTH = 8,
  parameter int HYST  = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] level,
  input  logic          push_ok,
  input  logic          pop,
  input  logic          starve,
  input  logic          underrun_clr,
  input  logic          req_ie,
  input  logic          urun_ie,
  output logic          samp_req,
  output logic          underrun,
  output logic          busy,
  output logic          irq
);
  logic at_mark, grow, shrink;

  assign at_mark = (level == LW'(HYST));
  assign grow    = push_ok && !pop;
  assign shrink  = pop && !push_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_req <= 1'b1;
      underrun <= 1'b0;
    end else begin
      samp_req <= asb_pkg::sreq_update(samp_req, at_mark, grow, shrink);
      if (starve) underrun <= 1'b1;
      else if (underrun_clr) underrun <= 1'b0;
    end
  end

  assign busy = (level == LW'(DEPTH));
  assign irq  = (samp_req && req_ie) || (underrun && urun_ie);
endmodule

// File: rtl/audio_sample_buffer.sv
module audio_sample_buffer
  import asb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int HYST  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SAMPLE_W-1:0] wr_byte,
  input  logic                rd_req,
  input  logic [DUP_W-1:0]    dup_sel,
  input  logic                underrun_clr,
  input  logic                req_ie,
  input  logic                urun_ie,
  output logic [OUT_W-1:0]    samp_out,
  output logic                samp_req,
  output logic                underrun,
  output logic                busy,
  output logic                irq
);
  localparam int LW = $clog2(DEPTH + 1);

  logic [SAMPLE_W-1:0] head;
  logic [LW-1:0]       level;
  logic push_ok, full, empty, pop, starve;

  asb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .pop(pop), .wdata(wr_byte),
    .rdata(head), .push_ok(push_ok), .full(full), .empty(empty), .level(level)
  );

  asb_repeater u_rep (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .dup_sel(dup_sel),
    .empty(empty), .head(head), .pop(pop), .starve(starve), .samp_out(samp_out)
  );

  asb_flags #(.DEPTH(DEPTH), .HYST(HYST)) u_flags (
    .clk(clk), .rst_n(rst_n), .level(level), .push_ok(push_ok), .pop(pop),
    .starve(starve), .underrun_clr(underrun_clr), .req_ie(req_ie),
    .urun_ie(urun_ie), .samp_req(samp_req), .underrun(underrun),
    .busy(busy), .irq(irq)
  );
endmodule

// File: rtl/asb_checker.sv
module asb_checker #(
  parameter int DEPTH = 8,
  parameter int HYST  = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_req,
  input logic          underrun_clr,
  input logic [15:0]   samp_out,
  input logic          samp_req,
  input logic          underrun,
  input logic          busy,
  input logic [LW-1:0] level,
  input logic          push_ok,
  input logic          pop,
  input logic          starve
);
  always_comb begin
    if (rst_n) assert_level_bound_R1: assert (level <= LW'(DEPTH));
  end

  assert_full_write_dropped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en && !pop |=> $stable(level));

  assert_low_byte_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    samp_out[7:0] == 8'h00);

  assert_sreq_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LW'(HYST)) && pop && !push_ok |=> samp_req);

  assert_sreq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LW'(HYST)) && push_ok && !pop |=> !samp_req);

  assert_underrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    starve |=> underrun);

  assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !underrun_clr |=> underrun);

  assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(level) == LW'(DEPTH - 1));

  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(samp_out));
endmodule

bind audio_sample_buffer asb_checker #(.DEPTH(DEPTH), .HYST(HYST)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_req(rd_req),
  .underrun_clr(underrun_clr), .samp_out(samp_out), .samp_req(samp_req),
  .underrun(underrun), .busy(busy), .level(level), .push_ok(push_ok),
  .pop(pop), .starve(starve)
);

// File: tb/audio_sample_buffer_tb.sv
module audio_sample_buffer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_req = 1'b0, underrun_clr = 1'b0;
  logic req_ie = 1'b0, urun_ie = 1'b0;
  logic [7:0] wr_byte = '0;
  logic [1:0] dup_sel = '0;
  logic [15:0] samp_out;
  logic samp_req, underrun, busy, irq;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  audio_sample_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte), .rd_req(rd_req),
    .dup_sel(dup_sel), .underrun_clr(underrun_clr), .req_ie(req_ie),
    .urun_ie(urun_ie), .samp_out(samp_out), .samp_req(samp_req),
    .underrun(underrun), .busy(busy), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, let a posedge pass, return at next negedge.
  task automatic cyc(input logic w, input logic [7:0] b, input logic r, input logic c);
    wr_en = w; wr_byte = b; rd_req = r; underrun_clr = c;
    @(negedge clk);
    wr_en = 0; rd_req = 0; underrun_clr = 0;
  endtask

  task automatic wr(input logic [7:0] b); cyc(1, b, 0, 0); endtask
  task automatic rd(input string req, input logic [7:0] exp_b);
    cyc(0, 8'h00, 1, 0);
    check(req, samp_out, {exp_b, 8'h00});
  endtask

  task automatic t_reset;
    check("R5 reset samp_req", samp_req, 1);
    check("R8 reset underrun", underrun, 0);
    check("R9 reset busy", busy, 0);
    check("R11 reset samp_out", samp_out, 0);
  endtask

  task automatic t_empty_start;
    rd("R7 zero before any byte", 8'h00);
    check("R7 underrun set", underrun, 1);
    urun_ie = 1; #0.1;
    check("R10 irq from underrun", irq, 1);
    cyc(0, 0, 0, 1);
    check("R8 clear", underrun, 0);
    check("R10 irq drops", irq, 0);
    urun_ie = 0; req_ie = 1; #0.1;
    check("R10 irq from samp_req", irq, 1);
    req_ie = 0;
    cyc(0, 0, 1, 1);
    check("R8 set wins over clear", underrun, 1);
    cyc(0, 0, 0, 0);
    check("R8 sticky", underrun, 1);
    cyc(0, 0, 0, 1);
  endtask

  task automatic t_fill_drain;
    dup_sel = 2'b00;
    for (int i = 1; i <= 8; i++) begin
      wr(8'(i * 8'h11));
      if (i == 4) check("R6 level 4 keeps request", samp_req, 1);
      if (i == 5) check("R6 cleared at 4->5", samp_req, 0);
      if (i == 7) check("R9 not busy at 7", busy, 0);
    end
    check("R9 busy at 8", busy, 1);
    wr(8'h99);
    check("R1 busy still after dropped write", busy, 1);
    for (int i = 1; i <= 8; i++) begin
      rd("R4 order / R2 padding", 8'(i * 8'h11));
      if (i == 1) check("R9 busy clears", busy, 0);
      if (i == 4) check("R6 no change 5->4", samp_req, 0);
      if (i == 5) check("R5 set at 4->3", samp_req, 1);
    end
    check("R7 no underrun yet", underrun, 0);
    rd("R1 dropped write absent / R7 holds last", 8'h88);
    check("R7 underrun on starve", underrun, 1);
    cyc(0, 0, 0, 1);
  endtask

  task automatic t_dup;
    dup_sel = 2'b10;
    wr(8'hA1); wr(8'hB2);
    for (int i = 0; i < 3; i++) rd("R3 x3 first", 8'hA1);
    for (int i = 0; i < 3; i++) rd("R3 x3 second", 8'hB2);
    check("R3 no underrun", underrun, 0);
    dup_sel = 2'b11;
    wr(8'hC3);
    for (int i = 0; i < 4; i++) rd("R3 x4", 8'hC3);
    check("R3 x4 exact", underrun, 0);
    rd("R7 hold", 8'hC3);
    check("R7 starve after x4", underrun, 1);
    cyc(0, 0, 0, 1);
    dup_sel = 2'b01;
    wr(8'hD4); wr(8'hE5);
    rd("R3 first of pair", 8'hD4);
    dup_sel = 2'b00;
    rd("R3 run keeps latched count", 8'hD4);
    rd("R3 new count applies", 8'hE5);
    check("R3 single repeat", underrun, 0);
    // R11: writes without requests leave the output untouched
    wr(8'h5A); cyc(0, 0, 0, 0);
    check("R11 stable without request", samp_out, 16'hE500);
    rd("R4 next", 8'h5A);
  endtask

  task automatic t_hyst;
    dup_sel = 2'b00;
    for (int i = 0; i < 4; i++) wr(8'h10 + 8'(i));
    check("R6 filling to 4 keeps set", samp_req, 1);
    rd("R4 h0", 8'h10);
    check("R5 stays set at 3", samp_req, 1);
    wr(8'h20); wr(8'h21);
    check("R6 cleared to 5", samp_req, 0);
    rd("R4 h1", 8'h11);
    check("R6 held at 4", samp_req, 0);
    cyc(1, 8'h22, 1, 0);
    check("R6 push+pop at 4 no change", samp_req, 0);
    check("R4 h2", samp_out, 16'h1200);
    rd("R4 h3", 8'h13);
    check("R5 set on 4->3", samp_req, 1);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty_start();
    t_fill_drain();
    t_dup();
    t_hyst();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule